// File: doc/BRIEF.md
# Nanosecond Alarm Timer

This peripheral keeps a free-running 64-bit count of nanoseconds and compares it against one 64-bit alarm value. Each clock cycle adds a fixed, parameterised number of nanoseconds to the count. Software reaches the block over a plain 32-bit register bus with address, write strobe, write data, read strobe and registered read data. The wide values are moved as two 32-bit halves. The upper half of the count is captured whenever the lower half is read. The upper halves of the time and alarm are staged until the lower half is written, so every 64-bit transfer is seen as one whole value.

Writing the lower alarm half arms the comparator. Once the count reaches or passes the alarm value, the alarm disarms itself and sets an interrupt-pending flag. The interrupt line is that flag gated by an enable bit, and it stays high until software acknowledges it. Software can also cancel an armed alarm before it fires.

Top module: `nstimer_top`

## Requirements
- R1: After reset the count advances by STEP_NS every clock cycle and wraps modulo 2^64. Its lower 32 bits are read at byte offset 0x00.
- R2: A read of 0x00 captures bits 63:32 of the count in the same cycle. Every later read of 0x04 returns that captured value until the next read of 0x00.
- R3: A write to 0x00 loads the count with {staged upper word, written data}. The read in the following cycle sees exactly that value, and counting resumes from it.
- R4: The alarm value is written as its upper half at 0x0C, then its lower half at 0x08. The write to 0x08 commits {staged upper, data} and arms the alarm. Reads of 0x08 and 0x0C return the committed alarm value.
- R5: A write to 0x04 or 0x0C changes neither the count nor the committed alarm value until the matching lower word is written.
- R6: When the alarm is armed and count >= alarm value, the next clock edge clears the armed state and sets the pending flag. An alarm value at or below the current count therefore fires one cycle after it is armed.
- R7: A write to 0x14 with bit 0 = 1 disarms the alarm without setting the pending flag. A write there with bit 0 = 0 has no effect.
- R8: Bit 0 of 0x10 is the interrupt enable and reads back in bit 0. irq_o is high exactly when the pending flag and the enable are both 1.
- R9: A write to 0x1C with bit 0 = 1 clears the pending flag, unless the alarm fires in the same cycle. A write there with bit 0 = 0 has no effect.
- R10: A read of 0x18 returns 1 while the alarm is armed and has not fired, and 0 otherwise.
- R11: Reset clears the count, the alarm value, armed, pending, enable and read data. Reads of 0x14, 0x1C and of any other unlisted offset return 0. Read data appears in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt: pending AND enable |

## Verification
Read data, loads, arming, cancel, acknowledge and enable changes all take effect at the clock edge that samples the strobe. Their results are sampled at the falling edge that follows. A comparison that succeeds at one edge shows up as a raised pending flag one edge later, so an alarm armed in the past has fired after two edges. The bench drives each bus operation for exactly one edge and keeps a cycle-stepped model that advances on the same edges. Every falling-edge sample is compared against the model and, in the directed cases, against hand-computed constants.

// File: rtl/nst_pkg.sv
package nst_pkg;

  localparam int unsigned OFS_W = 5;

  localparam logic [OFS_W-1:0] OFS_TIME_LO  = 5'h00;
  localparam logic [OFS_W-1:0] OFS_TIME_HI  = 5'h04;
  localparam logic [OFS_W-1:0] OFS_ALRM_LO  = 5'h08;
  localparam logic [OFS_W-1:0] OFS_ALRM_HI  = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_IRQ_EN   = 5'h10;
  localparam logic [OFS_W-1:0] OFS_CANCEL   = 5'h14;
  localparam logic [OFS_W-1:0] OFS_STATUS   = 5'h18;
  localparam logic [OFS_W-1:0] OFS_ACK      = 5'h1C;

  typedef struct packed {
    logic        time_ld;
    logic        alrm_ld;
    logic        en_wr;
    logic        en_val;
    logic        cancel;
    logic        ack;
    logic [63:0] ld_val;
  } nst_cmd_t;

endpackage

// File: rtl/nst_counter.sv
module nst_counter #(
  parameter int unsigned STEP_NS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_i,
  input  logic [63:0] ld_val_i,
  output logic [63:0] cnt_o
);

  localparam logic [63:0] STEP = 64'(STEP_NS);

  logic [63:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + STEP;
    if (ld_i) cnt_d = ld_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> cnt_q == $past(cnt_q) + STEP);

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> cnt_q == $past(ld_val_i));

endmodule

// File: rtl/nst_alarm.sv
module nst_alarm (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] cnt_i,
  input  logic        arm_i,
  input  logic [63:0] arm_val_i,
  input  logic        cancel_i,
  input  logic        ack_i,
  input  logic        en_wr_i,
  input  logic        en_val_i,
  output logic [63:0] cmp_o,
  output logic        armed_o,
  output logic        en_o,
  output logic        irq_o
);

  logic [63:0] cmp_q, cmp_d;
  logic        armed_q, armed_d;
  logic        pend_q, pend_d;
  logic        en_q, en_d;
  logic        fire;

  assign fire = armed_q & ~arm_i & ~cancel_i & (cnt_i >= cmp_q);

  always_comb begin
    cmp_d   = cmp_q;
    armed_d = armed_q;
    pend_d  = pend_q;
    en_d    = en_q;
    if (arm_i) begin
      cmp_d   = arm_val_i;
      armed_d = 1'b1;
    end else if (cancel_i || fire) begin
      armed_d = 1'b0;
    end
    if (fire)       pend_d = 1'b1;
    else if (ack_i) pend_d = 1'b0;
    if (en_wr_i)    en_d   = en_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      cmp_q   <= cmp_d;
      armed_q <= armed_d;
      pend_q  <= pend_d;
      en_q    <= en_d;
    end
  end

  assign cmp_o   = cmp_q;
  assign armed_o = armed_q;
  assign en_o    = en_q;
  assign irq_o   = pend_q & en_q;

  a_r6_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !arm_i && !cancel_i && cnt_i >= cmp_q) |=> (pend_q && !armed_q));

  a_r4_arm: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (armed_q && cmp_q == $past(arm_val_i)));

  a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel_i && !arm_i) |=> (!armed_q && pend_q == $past(pend_q)));

  a_r9_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !(armed_q && !arm_i && !cancel_i && cnt_i >= cmp_q)) |=> !irq_o);

endmodule

// File: rtl/nst_regbus.sv
module nst_regbus
  import nst_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  input  logic              rd_i,
  input  logic [63:0]       cnt_i,
  input  logic [63:0]       cmp_i,
  input  logic              armed_i,
  input  logic              en_i,
  output nst_cmd_t          cmd_o,
  output logic [31:0]       rdata_o
);

  logic hit_tlo, hit_thi, hit_alo, hit_ahi, hit_en, hit_can, hit_sts, hit_ack;

  assign hit_tlo = (addr_i == ADDR_W'(OFS_TIME_LO));
  assign hit_thi = (addr_i == ADDR_W'(OFS_TIME_HI));
  assign hit_alo = (addr_i == ADDR_W'(OFS_ALRM_LO));
  assign hit_ahi = (addr_i == ADDR_W'(OFS_ALRM_HI));
  assign hit_en  = (addr_i == ADDR_W'(OFS_IRQ_EN));
  assign hit_can = (addr_i == ADDR_W'(OFS_CANCEL));
  assign hit_sts = (addr_i == ADDR_W'(OFS_STATUS));
  assign hit_ack = (addr_i == ADDR_W'(OFS_ACK));

  logic [31:0] thi_q, thi_d;
  logic [31:0] ahi_q, ahi_d;
  logic [31:0] snap_q, snap_d;
  logic [31:0] rdata_q, rdata_d;
  logic [31:0] rd_mux;

  always_comb begin
    cmd_o         = '0;
    cmd_o.time_ld = wr_i & hit_tlo;
    cmd_o.alrm_ld = wr_i & hit_alo;
    cmd_o.en_wr   = wr_i & hit_en;
    cmd_o.en_val  = wdata_i[0];
    cmd_o.cancel  = wr_i & hit_can & wdata_i[0];
    cmd_o.ack     = wr_i & hit_ack & wdata_i[0];
    cmd_o.ld_val  = hit_tlo ? {thi_q, wdata_i} : {ahi_q, wdata_i};
  end

  always_comb begin
    rd_mux = '0;
    if (hit_tlo) rd_mux = cnt_i[31:0];
    if (hit_thi) rd_mux = snap_q;
    if (hit_alo) rd_mux = cmp_i[31:0];
    if (hit_ahi) rd_mux = cmp_i[63:32];
    if (hit_en)  rd_mux = {31'd0, en_i};
    if (hit_sts) rd_mux = {31'd0, armed_i};
  end

  always_comb begin
    thi_d   = thi_q;
    ahi_d   = ahi_q;
    snap_d  = snap_q;
    rdata_d = rdata_q;
    if (wr_i && hit_thi) thi_d  = wdata_i;
    if (wr_i && hit_ahi) ahi_d  = wdata_i;
    if (rd_i && hit_tlo) snap_d = cnt_i[63:32];
    if (rd_i)            rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thi_q   <= '0;
      ahi_q   <= '0;
      snap_q  <= '0;
      rdata_q <= '0;
    end else begin
      thi_q   <= thi_d;
      ahi_q   <= ahi_d;
      snap_q  <= snap_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

  a_r2_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && hit_tlo) |=> snap_q == $past(cnt_i[63:32]));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_q));

  a_r5_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && hit_thi) |=> thi_q == $past(wdata_i));

endmodule

// File: rtl/nstimer_top.sv
module nstimer_top
  import nst_pkg::*;
#(
  parameter int unsigned STEP_NS = 4,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  nst_cmd_t    cmd;
  logic [63:0] cnt;
  logic [63:0] cmp;
  logic        armed;
  logic        en;

  nst_regbus #(.ADDR_W(ADDR_W)) u_bus (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .addr_i  (bus_addr),
    .wr_i    (bus_wr),
    .wdata_i (bus_wdata),
    .rd_i    (bus_rd),
    .cnt_i   (cnt),
    .cmp_i   (cmp),
    .armed_i (armed),
    .en_i    (en),
    .cmd_o   (cmd),
    .rdata_o (bus_rdata)
  );

  nst_counter #(.STEP_NS(STEP_NS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ld_i     (cmd.time_ld),
    .ld_val_i (cmd.ld_val),
    .cnt_o    (cnt)
  );

  nst_alarm u_alm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cnt_i     (cnt),
    .arm_i     (cmd.alrm_ld),
    .arm_val_i (cmd.ld_val),
    .cancel_i  (cmd.cancel),
    .ack_i     (cmd.ack),
    .en_wr_i   (cmd.en_wr),
    .en_val_i  (cmd.en_val),
    .cmp_o     (cmp),
    .armed_o   (armed),
    .en_o      (en),
    .irq_o     (irq_o)
  );

  a_r11_reset_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (!irq_o && bus_rdata == 32'd0));

endmodule

// File: tb/tb_nstimer_top.sv
`timescale 1ns/1ps
module tb_nstimer_top;

  localparam int unsigned STEP = 4;
  localparam int unsigned AW   = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic          irq_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nstimer_top #(.STEP_NS(STEP), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // cycle-stepped expectation model, built from the requirements
  logic [63:0] m_cnt, m_cmp;
  logic [31:0] m_thi, m_ahi, m_snap, m_rdata;
  logic        m_armed, m_pend, m_en;
  int          m_rel;

  function automatic logic [31:0] f_read(input logic [AW-1:0] a);
    case (a)
      5'h00:   return m_cnt[31:0];
      5'h04:   return m_snap;
      5'h08:   return m_cmp[31:0];
      5'h0C:   return m_cmp[63:32];
      5'h10:   return {31'd0, m_en};
      5'h18:   return {31'd0, m_armed};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic fire, arm, can, ack;
    if (!rst_n) begin
      m_rel = 0; m_cnt = '0; m_cmp = '0; m_thi = '0; m_ahi = '0;
      m_snap = '0; m_rdata = '0; m_armed = 0; m_pend = 0; m_en = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      arm  = bus_wr && bus_addr == 5'h08;
      can  = bus_wr && bus_addr == 5'h14 && bus_wdata[0];
      ack  = bus_wr && bus_addr == 5'h1C && bus_wdata[0];
      fire = m_armed && !arm && !can && (m_cnt >= m_cmp);
      if (bus_rd) begin
        m_rdata = f_read(bus_addr);
        if (bus_addr == 5'h00) m_snap = m_cnt[63:32];
      end
      if (fire) m_pend = 1'b1; else if (ack) m_pend = 1'b0;
      if (arm) begin m_cmp = {m_ahi, bus_wdata}; m_armed = 1'b1; end
      else if (can || fire) m_armed = 1'b0;
      if (bus_wr && bus_addr == 5'h10) m_en = bus_wdata[0];
      if (bus_wr && bus_addr == 5'h00) m_cnt = {m_thi, bus_wdata};
      else m_cnt = m_cnt + 64'(STEP);
      if (bus_wr && bus_addr == 5'h04) m_thi = bus_wdata;
      if (bus_wr && bus_addr == 5'h0C) m_ahi = bus_wdata;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_irq(input string tag);
    chk(tag, "irq", {31'd0, irq_o}, {31'd0, m_pend & m_en});
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input string tag, input bit use_exp, input logic [31:0] exp);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, "rdata vs model", bus_rdata, m_rdata);
    if (use_exp) chk(tag, "rdata vs constant", bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      5'h00: return "R1";
      5'h04: return "R2";
      5'h08, 5'h0C: return "R4";
      5'h10: return "R8";
      5'h18: return "R10";
      default: return "R11";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] tgt;
    void'($urandom(32'd20231028));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R11 reset state
    chk("R11", "irq after reset", {31'd0, irq_o}, 32'd0);
    chk("R11", "rdata after reset", bus_rdata, 32'd0);
    rd(5'h10, "R11", 1, 32'd0);
    rd(5'h18, "R11", 1, 32'd0);
    rd(5'h08, "R11", 1, 32'd0);
    rd(5'h0C, "R11", 1, 32'd0);
    rd(5'h02, "R11", 1, 32'd0);
    rd(5'h14, "R11", 1, 32'd0);
    rd(5'h1C, "R11", 1, 32'd0);
    rd(5'h00, "R1", 0, 0);

    // R2 R3 snapshot across a carry
    wr(5'h04, 32'd1);
    wr(5'h00, 32'hFFFF_FFF0);
    rd(5'h00, "R3", 1, 32'hFFFF_FFF0);
    idle(8);
    rd(5'h04, "R2", 1, 32'd1);
    rd(5'h00, "R2", 0, 0);
    rd(5'h04, "R2", 1, 32'd2);

    // R1 wrap modulo 2^64
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h00, 32'hFFFF_FFFC);
    rd(5'h00, "R1", 1, 32'hFFFF_FFFC);
    rd(5'h00, "R1", 1, 32'd0);
    rd(5'h04, "R1", 1, 32'd0);

    // R6 alarm in the past fires one cycle after arming; R8 gating; R9 ack
    wr(5'h0C, 32'd0);
    wr(5'h08, 32'd0);
    rd(5'h18, "R10", 1, 32'd1);
    rd(5'h18, "R6", 1, 32'd0);
    chk("R8", "masked irq", {31'd0, irq_o}, 32'd0);
    wr(5'h10, 32'd1);
    chk("R8", "enabled irq", {31'd0, irq_o}, 32'd1);
    rd(5'h10, "R8", 1, 32'd1);
    wr(5'h1C, 32'd0);
    chk("R9", "ack bit0=0 ignored", {31'd0, irq_o}, 32'd1);
    wr(5'h1C, 32'd1);
    chk("R9", "ack clears", {31'd0, irq_o}, 32'd0);

    // R7 cancel
    wr(5'h0C, 32'hFFFF_0000);
    wr(5'h08, 32'd0);
    rd(5'h18, "R10", 1, 32'd1);
    wr(5'h14, 32'd0);
    rd(5'h18, "R7", 1, 32'd1);
    wr(5'h14, 32'd1);
    rd(5'h18, "R7", 1, 32'd0);
    chk("R7", "no irq after cancel", {31'd0, irq_o}, 32'd0);

    // R5 staging
    wr(5'h0C, 32'd5);
    rd(5'h0C, "R5", 1, 32'hFFFF_0000);
    wr(5'h04, 32'h77);
    rd(5'h00, "R5", 0, 0);
    rd(5'h04, "R5", 1, 32'd0);
    wr(5'h08, 32'd9);
    rd(5'h0C, "R4", 1, 32'd5);
    rd(5'h08, "R4", 1, 32'd9);
    wr(5'h14, 32'd1);

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int k;
      k = $urandom_range(0, 9);
      case (k)
        0, 1, 2: begin
          logic [4:0] a;
          a = 5'($urandom_range(0, 7) * 4);
          if ($urandom_range(0, 9) == 0) a = 5'($urandom);
          rd(a, tag_of(a), 0, 0);
        end
        3, 4: begin
          if ($urandom_range(0, 3) == 0) tgt = m_cnt - 64'($urandom_range(0, 40));
          else                            tgt = m_cnt + 64'($urandom_range(0, 300));
          wr(5'h0C, tgt[63:32]);
          wr(5'h08, tgt[31:0]);
          chk_irq("R6");
        end
        5: begin wr(5'h10, 32'($urandom_range(0, 1))); chk_irq("R8"); end
        6: begin wr(5'h1C, 32'($urandom_range(0, 1))); chk_irq("R9"); end
        7: begin wr(5'h14, 32'($urandom_range(0, 1))); chk_irq("R7"); end
        8: begin
          if ($urandom_range(0, 4) == 0) begin
            wr(5'h04, $urandom);
            wr(5'h00, $urandom);
            rd(5'h00, "R3", 0, 0);
          end else idle(1);
          chk_irq("R3");
        end
        default: begin idle($urandom_range(1, 20)); chk_irq("R6"); end
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule